// File: doc/BRIEF.md
# Pulse-Swallow Programmable Ratio Divider

This block divides a fast input clock by a programmable 15-bit ratio N. It produces one output pulse every N input cycles for a phase comparator, plus a half-rate square copy of that pulse stream that a test path can send to a port. The division uses three cooperating stages rather than one wide down-counter. The first is an 8/9 dual-modulus prescaler, written as synthesizable logic. The second is a 3-bit swallow counter that holds the prescaler at divide-by-9. The third is a 12-bit main counter that counts prescaler periods.

A ratio word is written through a one-cycle strobe. Bits [2:0] set the swallow count A and bits [14:3] set the main count M, which gives N = 8·M + A. The prescaler divides by 9 for the first A of the M prescaler periods and by 8 for the rest. A ratio is only usable when M is at least 1 and at least A. Any other word is refused and reported, and the divider keeps its current ratio. An accepted word waits in a holding register and is loaded into the counters only at the end of an output period, so no period is ever cut short.

Top module: `psd_divider`

## Requirements
- R1: `pd_pulse` is high for exactly one clock cycle, and consecutive pulses are exactly N cycles apart for the loaded ratio.
- R2: The ratio word splits as A = bits [2:0] and M = bits [14:3]. The prescaler divides by 9 while the swallow count is nonzero and by 8 after that, so the period is 8·M + A.
- R3: The largest ratio, 32767 (M = 4095, A = 7), gives a period of 32767 cycles.
- R4: A written word is refused when M = 0 or M < A. `ratio_rej` is then high for one cycle, the cycle after the write strobe, and the output period does not change. For an accepted word, `ratio_rej` stays low.
- R5: The smallest legal ratios (8 with M=1,A=0; 9 with M=1,A=1; 62 and 63 with M=7) give exactly those periods.
- R6: `pd_half` toggles on the same edge that raises `pd_pulse`, so it has a period of 2·N.
- R7: A word accepted during an output period takes effect only from the next period. The period in progress completes with the old ratio.
- R8: While synchronous `rst` is high, `pd_pulse`, `pd_half` and `ratio_rej` are 0. After `rst` falls, the first pulse comes RATIO_RST (default 100) cycles later.
- R9: When several legal words are written within one period, only the last one is loaded at the next boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| rst | input | 1 | Synchronous active-high reset |
| ratio_wr | input | 1 | One-cycle write strobe for `ratio_in` |
| ratio_in | input | 15 | Ratio word: [14:3] main count M, [2:0] swallow count A |
| pd_pulse | output | 1 | One-cycle pulse every N input cycles |
| pd_half | output | 1 | Divide-by-two copy of the pulse stream |
| ratio_rej | output | 1 | One-cycle flag: the last written word was refused |

## Verification
The assertions assume several things about the inputs. The reset ratio is legal. `rst` is held high for at least one edge before checking begins. `ratio_in` may carry any value, because the legality filter is what the invariants depend on. The counters may never see a pair with A greater than M, and the prescaler modulus may change only at a prescaler terminal count. The stimulus sends both refused and accepted words, and it always issues writes just after a pulse, so the period measured next must still use the old ratio. Every period is measured by counting cycles at the ports from one pulse to the next.

// File: rtl/psd_pkg.sv
package psd_pkg;
    localparam int A_W    = 3;
    localparam int M_W    = 12;
    localparam int N_W    = A_W + M_W;
    localparam int PRE_LO = 1 << A_W;            // low modulus, 8
    localparam int P_W    = $clog2(PRE_LO + 1);  // prescaler count width

    typedef logic [N_W-1:0] ratio_w_t;

    typedef struct packed {
        logic [M_W-1:0] m;   // main count, word bits [14:3]
        logic [A_W-1:0] a;   // swallow count, word bits [2:0]
    } ratio_t;

    function automatic ratio_t split_ratio(input ratio_w_t w);
        return ratio_t'(w);
    endfunction

    function automatic logic ratio_legal(input ratio_t r);
        return (r.m != '0) && (r.m >= {{(M_W-A_W){1'b0}}, r.a});
    endfunction
endpackage

// File: rtl/psd_prescaler.sv
module psd_prescaler
    import psd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic sel9,
    output logic tc
);
    logic [P_W-1:0] pcnt;

    assign tc = (pcnt == (sel9 ? P_W'(PRE_LO) : P_W'(PRE_LO - 1)));

    always_ff @(posedge clk) begin
        if (rst || tc) pcnt <= '0;
        else           pcnt <= pcnt + 1'b1;
    end

    // R2
    pre_range_chk: assert property (@(posedge clk) disable iff (rst)
        pcnt <= P_W'(PRE_LO));

    // R2
    modulus_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (sel9 != $past(sel9)) |-> $past(tc));
endmodule

// File: rtl/psd_counters.sv
module psd_counters
    import psd_pkg::*;
#(
    parameter logic [N_W-1:0] RATIO_RST = 15'd100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tc,
    input  ratio_t load,
    output logic   sel9,
    output logic   boundary
);
    localparam ratio_t RST_R = split_ratio(RATIO_RST);

    logic [M_W-1:0] m_cnt;
    logic [A_W-1:0] a_cnt;
    logic           m_last;

    assign m_last   = (m_cnt == M_W'(1));
    assign sel9     = (a_cnt != '0);
    assign boundary = tc && m_last;

    always_ff @(posedge clk) begin
        if (rst) begin
            m_cnt <= RST_R.m;
            a_cnt <= RST_R.a;
        end else if (tc) begin
            if (m_last) begin
                m_cnt <= load.m;
                a_cnt <= load.a;
            end else begin
                m_cnt <= m_cnt - 1'b1;
                if (a_cnt != '0) a_cnt <= a_cnt - 1'b1;
            end
        end
    end

    // R4
    swallow_le_main_chk: assert property (@(posedge clk) disable iff (rst)
        {{(M_W-A_W){1'b0}}, a_cnt} <= m_cnt);

    // R2
    main_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        m_cnt != '0);
endmodule

// File: rtl/psd_ratio_hold.sv
module psd_ratio_hold
    import psd_pkg::*;
#(
    parameter logic [N_W-1:0] RATIO_RST = 15'd100
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   wr,
    input  ratio_t wr_ratio,
    input  logic   boundary,
    output ratio_t next_ratio,
    output logic   rej
);
    localparam ratio_t RST_R = split_ratio(RATIO_RST);

    ratio_t pend, active;
    logic   pend_vld, ok;

    assign ok         = ratio_legal(wr_ratio);
    assign next_ratio = pend_vld ? pend : active;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= RST_R;
            active   <= RST_R;
            pend_vld <= 1'b0;
            rej      <= 1'b0;
        end else begin
            rej <= wr && !ok;
            if (boundary) begin
                active   <= next_ratio;
                pend_vld <= 1'b0;
            end
            if (wr && ok) begin
                pend     <= wr_ratio;
                pend_vld <= 1'b1;
            end
        end
    end

    // R4
    active_legal_chk: assert property (@(posedge clk) disable iff (rst)
        ratio_legal(active));

    // R7
    ratio_boundary_chk: assert property (@(posedge clk) disable iff (rst)
        (active != $past(active)) |-> $past(boundary));
endmodule

// File: rtl/psd_divider.sv
module psd_divider
    import psd_pkg::*;
#(
    parameter logic [N_W-1:0] RATIO_RST = 15'd100
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           ratio_wr,
    input  logic [N_W-1:0] ratio_in,
    output logic           pd_pulse,
    output logic           pd_half,
    output logic           ratio_rej
);
    logic   sel9, tc, boundary;
    ratio_t next_ratio;

    psd_prescaler u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel9 (sel9),
        .tc   (tc)
    );

    psd_counters #(.RATIO_RST(RATIO_RST)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .tc       (tc),
        .load     (next_ratio),
        .sel9     (sel9),
        .boundary (boundary)
    );

    psd_ratio_hold #(.RATIO_RST(RATIO_RST)) u_hold (
        .clk        (clk),
        .rst        (rst),
        .wr         (ratio_wr),
        .wr_ratio   (split_ratio(ratio_in)),
        .boundary   (boundary),
        .next_ratio (next_ratio),
        .rej        (ratio_rej)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            pd_pulse <= 1'b0;
            pd_half  <= 1'b0;
        end else begin
            pd_pulse <= boundary;
            pd_half  <= pd_half ^ boundary;
        end
    end

    // R1
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        pd_pulse |=> !pd_pulse);

    // R6
    half_tgl_chk: assert property (@(posedge clk) disable iff (rst)
        (pd_half != $past(pd_half)) |-> pd_pulse);
endmodule

// File: tb/psd_divider_tb_top.sv
`timescale 1ns/1ps
module psd_divider_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ratio_wr = 1'b0;
    logic [14:0] ratio_in = '0;
    logic        pd_pulse, pd_half, ratio_rej;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    psd_divider dut_i (
        .clk(clk), .rst(rst), .ratio_wr(ratio_wr), .ratio_in(ratio_in),
        .pd_pulse(pd_pulse), .pd_half(pd_half), .ratio_rej(ratio_rej)
    );

    localparam int NV = 11;
    localparam logic [14:0] VEC_R  [NV] = '{15'd8, 15'd9, 15'd10, 15'd63, 15'd0, 15'd7,
                                            15'd1000, 15'd77, 15'd4097, 15'd62, 15'd32767};
    localparam bit          VEC_OK [NV] = '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0,
                                            1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
    localparam string       VEC_T  [NV] = '{"R5", "R5", "R4", "R5", "R4", "R4",
                                            "R1", "R2", "R2", "R5", "R3"};

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    // Starts at a negedge where pd_pulse is high; counts cycles to the next pulse.
    task automatic period(input logic [14:0] r, input logic wr,
                          output int n, output logic rej);
        ratio_in = r;
        ratio_wr = wr;
        n = 0;
        rej = 1'b0;
        do begin
            @(negedge clk);
            if (n == 0) begin
                rej = ratio_rej;
                ratio_wr = 1'b0;
            end
            n++;
        end while (!pd_pulse);
    endtask

    task automatic do_reset(input string req);
        int n;
        logic rj;
        rst = 1'b1;
        ratio_wr = 1'b0;
        repeat (3) @(negedge clk);
        chk(req, int'(pd_pulse), 0);
        chk(req, int'(pd_half), 0);
        chk(req, int'(ratio_rej), 0);
        rst = 1'b0;
        period(15'd0, 1'b0, n, rj);
        chk("R8", n, 100);
    endtask

    initial begin
        int n, cur;
        logic rj;
        logic h0;

        do_reset("R8");
        cur = 100;

        for (int i = 0; i < NV; i++) begin
            period(VEC_R[i], 1'b1, n, rj);
            chk("R7", n, cur);
            chk("R4", int'(rj), VEC_OK[i] ? 0 : 1);
            if (VEC_OK[i]) cur = int'(VEC_R[i]);
            period(15'd0, 1'b0, n, rj);
            chk(VEC_T[i], n, cur);
        end

        do_reset("R8");

        // R9: two writes in one period, last one wins
        ratio_in = 15'd200;
        ratio_wr = 1'b1;
        @(negedge clk);
        ratio_in = 15'd300;
        @(negedge clk);
        ratio_wr = 1'b0;
        n = 2;
        while (!pd_pulse) begin
            @(negedge clk);
            n++;
        end
        chk("R7", n, 100);
        period(15'd0, 1'b0, n, rj);
        chk("R9", n, 300);

        // R6 and R1: half-rate toggle and single-cycle pulse
        h0 = pd_half;
        @(negedge clk);
        chk("R1", int'(pd_pulse), 0);
        chk("R6", int'(pd_half), int'(h0));
        n = 1;
        while (!pd_pulse) begin
            @(negedge clk);
            n++;
        end
        chk("R6", int'(pd_half), int'(!h0));
        period(15'd0, 1'b0, n, rj);
        chk("R6", int'(pd_half), int'(h0));

        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule